// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block is a synchronous front end for an asynchronous static RAM of 262,144 words by 4 bits. A host issues one request at a time on a simple request/acknowledge port: an 18-bit address, a write flag, 4 bits of write data, and 4 bits of read data returned with the acknowledge. On the memory side the controller drives active-low chip, output and write strobes, the address, and a split tristate data bus with separate out, out-enable and in signals. Every memory timing interval is expressed as a whole number of clock cycles set by parameters.

Sequencing is a state machine with five states. SC_IDLE holds every strobe high so the memory sits in automatic power-down. From SC_IDLE, an accepted read goes to SC_READ, which holds chip and output enable low for RD_CYCLES cycles. The read data is captured at the edge that ends SC_READ, and the machine returns to SC_IDLE. An accepted write goes to SC_TURN, where chip enable is low, output enable is high and the controller's driver is off, for TA_CYCLES cycles. SC_TURN leads to SC_STROBE, where write enable is low and the data is driven, for the larger of WE_PULSE_CYCLES and SETUP_CYCLES. SC_STROBE leads to SC_HOLD, where write enable is back high while the data is still driven, for HOLD_CYCLES cycles. SC_HOLD then returns to SC_IDLE. The acknowledge pulse is raised in the SC_IDLE cycle after a read or write completes, so a new request can be accepted in that same cycle. A synchronous reset returns the machine to SC_IDLE.

Top module: `sram_async_ctrl`

## Requirements
- R1: While the synchronous reset is sampled high, the next cycle has sram_ce_n, sram_oe_n and sram_we_n at 1, sram_dq_oe at 0, host_ack at 0 and host_rdata at 0.
- R2: Outside a transaction, sram_ce_n, sram_oe_n and sram_we_n are 1, sram_dq_oe is 0, and host_ack is 0 except in the cycle right after a transaction completes.
- R3: A request with host_write=0 that is sampled in the idle state gives exactly RD_CYCLES cycles with sram_ce_n=0, sram_oe_n=0, sram_we_n=1 and sram_dq_oe=0, starting in the next cycle.
- R4: The word on sram_dq_in at the edge that ends the read phase appears on host_rdata in the next cycle, together with a one-cycle host_ack. host_rdata then holds that value until another read completes.
- R5: A request with host_write=1 that is sampled in the idle state first gives TA_CYCLES cycles with sram_ce_n=0, sram_oe_n=1, sram_we_n=1 and sram_dq_oe=0.
- R6: The turnaround is followed by max(WE_PULSE_CYCLES, SETUP_CYCLES) cycles with sram_we_n=0, sram_ce_n=0, sram_oe_n=1, sram_dq_oe=1 and sram_dq_out equal to the captured write data.
- R7: After write enable rises, HOLD_CYCLES cycles follow with sram_we_n=1, sram_ce_n=0 and the data still driven unchanged. The next cycle is idle with a one-cycle host_ack.
- R8: sram_dq_oe is never 1 while sram_oe_n is 0, and sram_we_n is 0 only while sram_ce_n is 0 and sram_oe_n is 1.
- R9: Address, data, write flag and request changes made during a transaction have no effect: sram_addr and sram_dq_out keep the values captured at acceptance, and the phase lengths are unchanged.
- R10: A request that is high in the acknowledge cycle is accepted, and its first phase begins in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Request, sampled in the idle state |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 18 | Word address |
| host_wdata | input | 4 | Write data |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 4 | Data of the last completed read |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_addr | output | 18 | Memory address |
| sram_dq_out | output | 4 | Data toward the memory |
| sram_dq_oe | output | 1 | Enable of the controller's data driver |
| sram_dq_in | input | 4 | Data from the memory |

## Verification
Completion and acceptance can fall in the same cycle: the idle cycle that carries host_ack for one transaction is also the cycle in which the next request is sampled. The bench provokes this by keeping host_req high through the acknowledge cycle, chaining write into read and read into write. The reference model then expects both the acknowledge, with its read data, and the first phase strobes of the new transaction one cycle later. The bus direction is checked on every cycle of these hand-overs, so a turnaround skipped after a read shows up as a mismatch.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        SC_IDLE,
        SC_READ,
        SC_TURN,
        SC_STROBE,
        SC_HOLD
    } sc_state_e;

    function automatic int unsigned cyc_max(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // bits needed to hold the values 0 .. n-1
    function automatic int unsigned cnt_width(int unsigned n);
        return (n < 3) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
`timescale 1ns/1ps
module sram_ctrl_timer #(
    parameter int unsigned CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_val;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign done = (remain_q == '0);
endmodule

// File: rtl/sram_ctrl_fsm.sv
`timescale 1ns/1ps
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned CNT_W         = 2,
    parameter int unsigned RD_CYCLES     = 2,
    parameter int unsigned TA_CYCLES     = 1,
    parameter int unsigned WE_LOW_CYCLES = 1,
    parameter int unsigned HOLD_CYCLES   = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             req_write,
    input  logic             tmr_done,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             accept,
    output logic             rd_done,
    output logic             wr_done,
    output logic             ce_n,
    output logic             oe_n,
    output logic             we_n,
    output logic             dq_oe
);
    localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_CYCLES - 1);
    localparam logic [CNT_W-1:0] TA_LD   = CNT_W'(TA_CYCLES - 1);
    localparam logic [CNT_W-1:0] WE_LD   = CNT_W'(WE_LOW_CYCLES - 1);
    localparam logic [CNT_W-1:0] HOLD_LD = CNT_W'(HOLD_CYCLES - 1);

    sc_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= SC_IDLE;
        else     state_q <= state_d;
    end

    // next state and phase timer loads
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        rd_done  = 1'b0;
        wr_done  = 1'b0;
        unique case (state_q)
            SC_IDLE: begin
                if (req) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    if (req_write) begin
                        state_d = SC_TURN;
                        tmr_val = TA_LD;
                    end else begin
                        state_d = SC_READ;
                        tmr_val = RD_LD;
                    end
                end
            end
            SC_READ: begin
                if (tmr_done) begin
                    state_d = SC_IDLE;
                    rd_done = 1'b1;
                end
            end
            SC_TURN: begin
                if (tmr_done) begin
                    state_d  = SC_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = WE_LD;
                end
            end
            SC_STROBE: begin
                if (tmr_done) begin
                    state_d  = SC_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = HOLD_LD;
                end
            end
            SC_HOLD: begin
                if (tmr_done) begin
                    state_d = SC_IDLE;
                    wr_done = 1'b1;
                end
            end
            default: state_d = SC_IDLE;
        endcase
    end

    // strobes registered from the next state: glitch-free at the pins
    always_ff @(posedge clk) begin
        if (rst) begin
            ce_n  <= 1'b1;
            oe_n  <= 1'b1;
            we_n  <= 1'b1;
            dq_oe <= 1'b0;
        end else begin
            unique case (state_d)
                SC_IDLE:   begin ce_n <= 1'b1; oe_n <= 1'b1; we_n <= 1'b1; dq_oe <= 1'b0; end
                SC_READ:   begin ce_n <= 1'b0; oe_n <= 1'b0; we_n <= 1'b1; dq_oe <= 1'b0; end
                SC_TURN:   begin ce_n <= 1'b0; oe_n <= 1'b1; we_n <= 1'b1; dq_oe <= 1'b0; end
                SC_STROBE: begin ce_n <= 1'b0; oe_n <= 1'b1; we_n <= 1'b0; dq_oe <= 1'b1; end
                SC_HOLD:   begin ce_n <= 1'b0; oe_n <= 1'b1; we_n <= 1'b1; dq_oe <= 1'b1; end
                default:   begin ce_n <= 1'b1; oe_n <= 1'b1; we_n <= 1'b1; dq_oe <= 1'b0; end
            endcase
        end
    end
endmodule

// File: rtl/sram_ctrl_regs.sv
`timescale 1ns/1ps
module sram_ctrl_regs #(
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              rd_done,
    input  logic              wr_done,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ack
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else if (accept) begin
            mem_addr  <= host_addr;
            mem_wdata <= host_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            ack   <= 1'b0;
        end else begin
            ack <= rd_done | wr_done;
            if (rd_done) rdata <= dq_in;
        end
    end
endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W          = 18,
    parameter int unsigned DATA_W          = 4,
    parameter int unsigned RD_CYCLES       = 2,
    parameter int unsigned TA_CYCLES       = 1,
    parameter int unsigned WE_PULSE_CYCLES = 1,
    parameter int unsigned SETUP_CYCLES    = 1,
    parameter int unsigned HOLD_CYCLES     = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_write,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ack,
    output logic [DATA_W-1:0] host_rdata,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);
    localparam int unsigned WE_LOW_CYCLES = cyc_max(WE_PULSE_CYCLES, SETUP_CYCLES);
    localparam int unsigned LONGEST = cyc_max(cyc_max(RD_CYCLES, TA_CYCLES),
                                              cyc_max(WE_LOW_CYCLES, HOLD_CYCLES));
    localparam int unsigned CNT_W = cnt_width(LONGEST);

    logic             tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_val;
    logic             accept, rd_done, wr_done;

    sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_ctrl_fsm #(
        .CNT_W         (CNT_W),
        .RD_CYCLES     (RD_CYCLES),
        .TA_CYCLES     (TA_CYCLES),
        .WE_LOW_CYCLES (WE_LOW_CYCLES),
        .HOLD_CYCLES   (HOLD_CYCLES)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req       (host_req),
        .req_write (host_write),
        .tmr_done  (tmr_done),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .accept    (accept),
        .rd_done   (rd_done),
        .wr_done   (wr_done),
        .ce_n      (sram_ce_n),
        .oe_n      (sram_oe_n),
        .we_n      (sram_we_n),
        .dq_oe     (sram_dq_oe)
    );

    sram_ctrl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .rd_done    (rd_done),
        .wr_done    (wr_done),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .dq_in      (sram_dq_in),
        .mem_addr   (sram_addr),
        .mem_wdata  (sram_dq_out),
        .rdata      (host_rdata),
        .ack        (host_ack)
    );
endmodule

// File: rtl/sram_ctrl_chk.sv
`timescale 1ns/1ps
module sram_ctrl_chk #(
    parameter int unsigned ADDR_W          = 18,
    parameter int unsigned DATA_W          = 4,
    parameter int unsigned RD_CYCLES       = 2,
    parameter int unsigned WE_PULSE_CYCLES = 1,
    parameter int unsigned SETUP_CYCLES    = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              host_ack,
    input logic [DATA_W-1:0] host_rdata,
    input logic              sram_ce_n,
    input logic              sram_oe_n,
    input logic              sram_we_n,
    input logic              sram_dq_oe,
    input logic [ADDR_W-1:0] sram_addr,
    input logic [DATA_W-1:0] sram_dq_out
);
    localparam int unsigned WE_LOW =
        (WE_PULSE_CYCLES > SETUP_CYCLES) ? WE_PULSE_CYCLES : SETUP_CYCLES;

    logic [15:0] rd_run, we_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_run <= '0;
            we_run <= '0;
        end else begin
            rd_run <= !sram_oe_n ? rd_run + 16'd1 : 16'd0;
            we_run <= !sram_we_n ? we_run + 16'd1 : 16'd0;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe && !host_ack));

    assert_ack_when_deselected_R2: assert property (@(posedge clk) disable iff (rst)
        host_ack |-> sram_ce_n);

    assert_read_strobes_R3: assert property (@(posedge clk) disable iff (rst)
        !sram_oe_n |-> (!sram_ce_n && sram_we_n));

    assert_read_not_long_R3: assert property (@(posedge clk) disable iff (rst)
        !sram_oe_n |-> (rd_run < 16'(RD_CYCLES)));

    assert_read_len_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_oe_n) |-> (rd_run == 16'(RD_CYCLES)));

    assert_ack_single_R4: assert property (@(posedge clk) disable iff (rst)
        host_ack |=> !host_ack);

    assert_strobe_drives_R6: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> sram_dq_oe);

    assert_strobe_len_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we_n) |-> (we_run == 16'(WE_LOW)));

    assert_hold_data_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we_n) |-> (sram_dq_oe && !sram_ce_n && $stable(sram_dq_out)));

    assert_no_contention_R8: assert property (@(posedge clk) disable iff (rst)
        sram_dq_oe |-> sram_oe_n);

    assert_we_gated_R8: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> (!sram_ce_n && sram_oe_n));

    assert_addr_stable_R9: assert property (@(posedge clk) disable iff (rst)
        (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));
endmodule

bind sram_async_ctrl sram_ctrl_chk #(
    .ADDR_W          (ADDR_W),
    .DATA_W          (DATA_W),
    .RD_CYCLES       (RD_CYCLES),
    .WE_PULSE_CYCLES (WE_PULSE_CYCLES),
    .SETUP_CYCLES    (SETUP_CYCLES)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .host_ack    (host_ack),
    .host_rdata  (host_rdata),
    .sram_ce_n   (sram_ce_n),
    .sram_oe_n   (sram_oe_n),
    .sram_we_n   (sram_we_n),
    .sram_dq_oe  (sram_dq_oe),
    .sram_addr   (sram_addr),
    .sram_dq_out (sram_dq_out)
);

// File: tb/tb_sram_async_ctrl.sv
`timescale 1ns/1ps
module tb_sram_async_ctrl;
    localparam int RD   = 3;
    localparam int TA   = 2;
    localparam int WEP  = 2;
    localparam int SU   = 1;
    localparam int HOLD = 1;
    localparam int WEL  = (WEP > SU) ? WEP : SU;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0, host_write = 1'b0;
    logic [17:0] host_addr = '0;
    logic [3:0]  host_wdata = '0;
    logic        host_ack;
    logic [3:0]  host_rdata;
    logic        sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
    logic [17:0] sram_addr;
    logic [3:0]  sram_dq_out;
    logic [3:0]  sram_dq_in = '0;

    always #2.5 clk = ~clk;

    sram_async_ctrl #(
        .RD_CYCLES(RD), .TA_CYCLES(TA), .WE_PULSE_CYCLES(WEP),
        .SETUP_CYCLES(SU), .HOLD_CYCLES(HOLD)
    ) dut (
        .clk(clk), .rst(rst), .host_req(host_req), .host_write(host_write),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
        .host_rdata(host_rdata), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n), .sram_addr(sram_addr), .sram_dq_out(sram_dq_out),
        .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
    );

    // expected cycle: strobes {ce_n,oe_n,we_n,dq_oe}
    typedef struct packed {
        logic [3:0]  strb;
        logic        ack;
        logic        wr;
        logic        idle;
        logic [17:0] a;
        logic [3:0]  d;
        logic [3:0]  tag;
    } exp_t;

    exp_t       q[$];
    logic [3:0] mdl_mem [int];
    logic [3:0] pin_mem [int];
    logic [3:0] last_rd = '0;
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // memory seen at the pins: a write lands when write enable rises
    always @(posedge sram_we_n) begin
        if (sram_ce_n === 1'b0) pin_mem[int'(sram_addr)] = sram_dq_out;
    end

    function automatic string tname(logic [3:0] t);
        case (t)
            4'd1:    return "R1";
            4'd3:    return "R3";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd10:   return "R10";
            default: return "R2";
        endcase
    endfunction

    function automatic exp_t mk(logic [3:0] s, logic ack, logic wr, logic idle,
                                logic [17:0] a, logic [3:0] d, logic [3:0] t);
        exp_t e;
        e.strb = s; e.ack = ack; e.wr = wr; e.idle = idle; e.a = a; e.d = d; e.tag = t;
        return e;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push_xact(bit wr, logic [17:0] a, logic [3:0] d, bit chained);
        logic [3:0] first;
        first = chained ? 4'd10 : (wr ? 4'd5 : 4'd3);
        if (!wr) begin
            for (int i = 0; i < RD; i++)
                q.push_back(mk(4'b0010, 0, 0, 0, a, d, (i == 0) ? first : 4'd3));
            q.push_back(mk(4'b1110, 1, 0, 1, a, d, 4'd3));
        end else begin
            for (int i = 0; i < TA; i++)
                q.push_back(mk(4'b0110, 0, 1, 0, a, d, (i == 0) ? first : 4'd5));
            for (int i = 0; i < WEL; i++)
                q.push_back(mk(4'b0101, 0, 1, 0, a, d, 4'd6));
            for (int i = 0; i < HOLD; i++)
                q.push_back(mk(4'b0111, 0, 1, 0, a, d, 4'd7));
            q.push_back(mk(4'b1110, 1, 1, 1, a, d, 4'd7));
        end
    endtask

    // one cycle: compare at the falling edge, then drive the next inputs
    task automatic step(bit req, bit wr, logic [17:0] a, logic [3:0] d, bit r);
        exp_t e;
        bit   was_idle;
        bit   ack_cyc;
        @(negedge clk);
        ack_cyc = 0;
        if (rst) begin
            q.delete();
            last_rd = '0;
            chk({sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe} == 4'b1110, "R1", "strobes",
                {sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe}, 4'b1110);
            chk(host_ack == 1'b0, "R1", "ack", host_ack, 0);
            chk(host_rdata == 4'h0, "R1", "rdata", host_rdata, 0);
            was_idle = 1;
        end else begin
            e = (q.size() > 0) ? q.pop_front() : mk(4'b1110, 0, 0, 1, '0, '0, 4'd2);
            if (e.ack && !e.wr) last_rd = mdl_mem.exists(int'(e.a)) ? mdl_mem[int'(e.a)] : 4'h0;
            if (e.ack && e.wr)  mdl_mem[int'(e.a)] = e.d;
            chk({sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe} == e.strb, tname(e.tag), "strobes",
                {sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe}, e.strb);
            chk(host_ack == e.ack, e.wr ? "R7" : (e.ack ? "R4" : "R2"), "ack", host_ack, e.ack);
            chk(host_rdata == last_rd, "R4", "rdata", host_rdata, last_rd);
            if (!e.strb[3]) chk(sram_addr == e.a, "R9", "addr", sram_addr, e.a);
            if (e.strb[0])  chk(sram_dq_out == e.d, "R6", "dq_out", sram_dq_out, e.d);
            chk(!(sram_dq_oe && !sram_oe_n), "R8", "contention", sram_dq_oe, 0);
            was_idle = e.idle;
            ack_cyc  = e.ack;
        end
        sram_dq_in = (!sram_ce_n && !sram_oe_n && !rst)
                   ? (pin_mem.exists(int'(sram_addr)) ? pin_mem[int'(sram_addr)] : 4'h0) : 4'h0;
        rst = r; host_req = req; host_write = wr; host_addr = a; host_wdata = d;
        if (!r && was_idle && req) push_xact(wr, a, d, ack_cyc);
    endtask

    // issue one transaction; junk with request high while busy (R9)
    task automatic xact(bit wr, logic [17:0] a, logic [3:0] d);
        step(1, wr, a, d, 0);
        while (q.size() > 1)
            step(1, 1'($urandom), 18'($urandom), 4'($urandom), 0);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, '0, '0, 0);
    endtask

    initial begin
        @(posedge clk);
        for (int i = 0; i < 3; i++) step(0, 0, '0, '0, 1);   // R1
        idle(3);                                              // R2
        xact(1, 18'h00000, 4'hA); idle(1);                    // R5 R6 R7
        xact(1, 18'h3FFFF, 4'h5); idle(2);
        xact(1, 18'h12345, 4'hF); idle(1);
        xact(1, 18'h00001, 4'h0); idle(1);
        xact(0, 18'h00000, 4'h0); idle(1);                    // R3 R4
        xact(0, 18'h3FFFF, 4'h0); idle(1);
        xact(0, 18'h12345, 4'h0); idle(3);
        xact(0, 18'h00001, 4'h0); idle(1);
        // R10: write chained into read, read chained into write
        xact(1, 18'h2AAAA, 4'h3);
        xact(0, 18'h2AAAA, 4'h0);
        xact(1, 18'h2AAAA, 4'hC);
        xact(0, 18'h2AAAA, 4'h0);
        idle(2);
        // reset during the turnaround of a write (R1)
        step(1, 1, 18'h01000, 4'h7, 0);
        step(0, 0, '0, '0, 1);
        step(0, 0, '0, '0, 1);
        idle(2);
        xact(0, 18'h01000, 4'h0); idle(1);
        // random mix over a few addresses, sometimes chained
        for (int i = 0; i < 60; i++) begin
            xact(1'($urandom), {15'h0, 3'($urandom)}, 4'($urandom));
            if ($urandom % 2) idle(1 + $urandom % 2);
        end
        idle(4);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule